// File: doc/BRIEF.md
# Shadowed Precision Time Counter

This block is a free-running hardware time-of-day clock for packet timestamping. It holds a 96-bit time made of three 32-bit words: a high word of nanoseconds, a low word of nanoseconds, and a fractional word of sub-nanoseconds. On every cycle in which the `tick` input is high, it adds a programmable 40-bit increment to the time. The upper 8 bits of the increment are whole nanoseconds and the lower 32 bits are a fraction of a nanosecond.

Software never changes the running time, the increment or an offset directly. It first fills shadow registers over a simple write bus. It then writes a command code, and finally writes a separate trigger register with the execute value. The staged change is applied one clock later. It is applied in the same cycle to the main timer and to a port-side mirror timer, which must always equal the lower 64 bits of the main timer.

A snapshot command copies all three time words into read-back registers in a single cycle. Software can therefore read a coherent time with several bus reads.

Top module: `phc_shadow_timer`

## Requirements
- R1: After reset the time, the mirror time, the command register and the read-back registers are all zero, and the increment is 0x01_0000_0000 (exactly 1 ns per tick).
- R2: Time is the concatenation {high, low, fraction}. Each cycle with `tick` high adds the 40-bit increment to it, with all carries (fraction into low, low into high) resolved in that same cycle. With `tick` low and no command being applied, the time holds.
- R3: Writes to the shadow or command registers alone never change the timer. Only a write of 0x1 to the trigger address starts a command, and any other value written there is ignored. Word addresses: 0x0 shadow time low, 0x1 shadow time high, 0x2 shadow adjust low, 0x3 shadow adjust high, 0x4 command, 0x5 trigger, 0x6/0x7/0x8 read-back fraction/low/high.
- R4: A triggered command takes effect at the clock edge after the edge that samples the trigger write.
- R5: Command code 1 (load time) sets the time to {shadow high, shadow low, 0}.
- R6: Command code 2 (load increment) sets the increment to {shadow adjust high[7:0], shadow adjust low}. Bits 31:8 of shadow adjust high are ignored.
- R7: Command codes 3 (shift) and 5 (shift at time, handled identically) add shadow adjust high to the time as a signed two's-complement number of nanoseconds, with borrow and carry into the high word. The fraction word is left unchanged.
- R8: Command code 4 (snapshot) copies the fraction, low and high words present at the apply edge into the read-back registers. They hold that value until the next snapshot.
- R9: The 3-bit command register reads 0 after every execute trigger. Codes 0, 6 and 7 change neither the time nor the increment.
- R10: The 64-bit mirror port time equals bits 63:0 of the main time in every cycle, including after each command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable: add the increment this cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| time_o | output | 96 | Main time {high, low, fraction} |
| port_time_o | output | 64 | Mirror timer, lower 64 bits of time |

## Verification
A wrong increment register or a lost carry shows at `time_o` after the first tick. Each sweep step compares the full 96 bits against an arithmetic model, so such an error is reported within one step. A command applied early, late or without a valid trigger changes `time_o` at the wrong edge. The bench samples two edges after each trigger and also holds off the trigger to catch this. A mirror timer that drifts from the main timer is caught at every check, because every time comparison also compares `port_time_o` with the low 64 bits. A stale or torn snapshot shows when the read-back words are read after the time has moved on.

// File: rtl/phc_pkg.sv
package phc_pkg;
  localparam int WORD_W  = 32;
  localparam int INC_W   = 40;
  localparam int ADDR_W  = 4;

  typedef enum logic [2:0] {
    CMD_NONE       = 3'd0,
    CMD_LOAD_TIME  = 3'd1,
    CMD_LOAD_INC   = 3'd2,
    CMD_SHIFT_TIME = 3'd3,
    CMD_SNAPSHOT   = 3'd4,
    CMD_SHIFT_AT   = 3'd5
  } phc_cmd_e;

  localparam logic [ADDR_W-1:0] A_SH_LO  = 4'h0;
  localparam logic [ADDR_W-1:0] A_SH_HI  = 4'h1;
  localparam logic [ADDR_W-1:0] A_ADJ_LO = 4'h2;
  localparam logic [ADDR_W-1:0] A_ADJ_HI = 4'h3;
  localparam logic [ADDR_W-1:0] A_CMD    = 4'h4;
  localparam logic [ADDR_W-1:0] A_SYNC   = 4'h5;
  localparam logic [ADDR_W-1:0] A_RB_FR  = 4'h6;
  localparam logic [ADDR_W-1:0] A_RB_LO  = 4'h7;
  localparam logic [ADDR_W-1:0] A_RB_HI  = 4'h8;

  localparam logic [WORD_W-1:0] SYNC_GO = 32'h1;
endpackage

// File: rtl/phc_regs.sv
module phc_regs
  import phc_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [3*W-1:0] rb_time,
  output logic [W-1:0]  sh_lo,
  output logic [W-1:0]  sh_hi,
  output logic [W-1:0]  adj_lo,
  output logic [W-1:0]  adj_hi,
  output logic          exec_o,
  output logic [2:0]    exec_cmd_o,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] sh_lo_q, sh_hi_q, adj_lo_q, adj_hi_q;
  logic [W-1:0] sh_lo_n, sh_hi_n, adj_lo_n, adj_hi_n;
  logic [2:0]   cmd_q, cmd_n, xcmd_q, xcmd_n;
  logic         exec_q, exec_n;
  logic         sync_hit;

  assign sync_hit = wr && (addr == A_SYNC) && (wdata == SYNC_GO);

  always_comb begin
    sh_lo_n  = sh_lo_q;
    sh_hi_n  = sh_hi_q;
    adj_lo_n = adj_lo_q;
    adj_hi_n = adj_hi_q;
    cmd_n    = cmd_q;
    xcmd_n   = xcmd_q;
    exec_n   = 1'b0;
    if (wr) begin
      case (addr)
        A_SH_LO:  sh_lo_n  = wdata;
        A_SH_HI:  sh_hi_n  = wdata;
        A_ADJ_LO: adj_lo_n = wdata;
        A_ADJ_HI: adj_hi_n = wdata;
        A_CMD:    cmd_n    = wdata[2:0];
        default:  ;
      endcase
    end
    if (sync_hit) begin
      exec_n = 1'b1;
      xcmd_n = cmd_q;
      cmd_n  = 3'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_lo_q  <= '0;
      sh_hi_q  <= '0;
      adj_lo_q <= '0;
      adj_hi_q <= '0;
      cmd_q    <= '0;
      xcmd_q   <= '0;
      exec_q   <= 1'b0;
    end else begin
      sh_lo_q  <= sh_lo_n;
      sh_hi_q  <= sh_hi_n;
      adj_lo_q <= adj_lo_n;
      adj_hi_q <= adj_hi_n;
      cmd_q    <= cmd_n;
      xcmd_q   <= xcmd_n;
      exec_q   <= exec_n;
    end
  end

  always_comb begin
    case (addr)
      A_SH_LO:  rdata = sh_lo_q;
      A_SH_HI:  rdata = sh_hi_q;
      A_ADJ_LO: rdata = adj_lo_q;
      A_ADJ_HI: rdata = adj_hi_q;
      A_CMD:    rdata = {{(W-3){1'b0}}, cmd_q};
      A_RB_FR:  rdata = rb_time[W-1:0];
      A_RB_LO:  rdata = rb_time[2*W-1:W];
      A_RB_HI:  rdata = rb_time[3*W-1:2*W];
      default:  rdata = '0;
    endcase
  end

  assign sh_lo      = sh_lo_q;
  assign sh_hi      = sh_hi_q;
  assign adj_lo     = adj_lo_q;
  assign adj_hi     = adj_hi_q;
  assign exec_o     = exec_q;
  assign exec_cmd_o = xcmd_q;

  // R4
  exec_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |=> exec_q);
  // R9
  cmd_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |=> (cmd_q == 3'd0));
  // R3
  no_trigger_no_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_hit |=> !exec_q);
endmodule

// File: rtl/phc_accum.sv
module phc_accum
  import phc_pkg::*;
#(
  parameter int              W       = WORD_W,
  parameter int              NW      = 3,
  parameter int              IW      = INC_W,
  parameter logic [IW-1:0]   INC_RST = 40'h01_0000_0000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           exec,
  input  logic [2:0]     exec_cmd,
  input  logic [W-1:0]   sh_lo,
  input  logic [W-1:0]   sh_hi,
  input  logic [W-1:0]   adj_lo,
  input  logic [W-1:0]   adj_hi,
  output logic [NW*W-1:0] time_o
);
  localparam int TW = NW * W;
  localparam int FW = 3 * W;

  logic [TW-1:0] time_q, time_n, base, step;
  logic [IW-1:0] inc_q, inc_n;
  logic [FW-1:0] load_full, adj_full;
  logic          time_en, inc_en;

  assign load_full = {sh_hi, sh_lo, {W{1'b0}}};
  assign adj_full  = {{W{adj_hi[W-1]}}, adj_hi, {W{1'b0}}};
  assign step      = tick ? {{(TW-IW){1'b0}}, inc_q} : '0;
  assign base      = time_q + step;

  always_comb begin
    time_n = base;
    inc_n  = inc_q;
    inc_en = 1'b0;
    if (exec) begin
      case (exec_cmd)
        CMD_LOAD_TIME: time_n = load_full[TW-1:0];
        CMD_LOAD_INC: begin
          inc_n  = {adj_hi[IW-W-1:0], adj_lo};
          inc_en = 1'b1;
        end
        CMD_SHIFT_TIME, CMD_SHIFT_AT: time_n = base + adj_full[TW-1:0];
        default: ;
      endcase
    end
  end

  assign time_en = tick | exec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
      inc_q  <= INC_RST;
    end else begin
      if (time_en) time_q <= time_n;
      if (inc_en)  inc_q  <= inc_n;
    end
  end

  assign time_o = time_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !exec) |=> $stable(time_q));
  // R5
  load_frac_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && exec_cmd == CMD_LOAD_TIME) |=> (time_q[W-1:0] == '0));
  // R6
  inc_only_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec && exec_cmd == CMD_LOAD_INC) |=> $stable(inc_q));
endmodule

// File: rtl/phc_shadow_timer.sv
module phc_shadow_timer
  import phc_pkg::*;
#(
  parameter int            W       = WORD_W,
  parameter int            AW      = ADDR_W,
  parameter int            IW      = INC_W,
  parameter logic [IW-1:0] INC_RST = 40'h01_0000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic [3*W-1:0] time_o,
  output logic [2*W-1:0] port_time_o
);
  localparam int MAIN_NW = 3;
  localparam int PORT_NW = 2;

  logic [W-1:0]   sh_lo, sh_hi, adj_lo, adj_hi;
  logic           exec;
  logic [2:0]     exec_cmd;
  logic [3*W-1:0] main_time;
  logic [2*W-1:0] port_time;
  logic [3*W-1:0] rb_q, rb_n;
  logic           snap_en;

  phc_regs #(.W(W), .AW(AW)) u_regs (
    .clk, .rst_n,
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rb_time(rb_q),
    .sh_lo, .sh_hi, .adj_lo, .adj_hi,
    .exec_o(exec), .exec_cmd_o(exec_cmd),
    .rdata(bus_rdata)
  );

  phc_accum #(.W(W), .NW(MAIN_NW), .IW(IW), .INC_RST(INC_RST)) u_main (
    .clk, .rst_n, .tick, .exec, .exec_cmd,
    .sh_lo, .sh_hi, .adj_lo, .adj_hi,
    .time_o(main_time)
  );

  phc_accum #(.W(W), .NW(PORT_NW), .IW(IW), .INC_RST(INC_RST)) u_port (
    .clk, .rst_n, .tick, .exec, .exec_cmd,
    .sh_lo, .sh_hi, .adj_lo, .adj_hi,
    .time_o(port_time)
  );

  assign snap_en = exec && (exec_cmd == CMD_SNAPSHOT);
  assign rb_n    = main_time;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rb_q <= '0;
    else if (snap_en) rb_q <= rb_n;
  end

  assign time_o      = main_time;
  assign port_time_o = port_time;

  // R10
  mirror_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_time == main_time[2*W-1:0]);
  // R8
  snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_en |=> $stable(rb_q));
endmodule

// File: tb/test_phc_shadow_timer.sv
module test_phc_shadow_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [95:0] time_o;
  logic [63:0] port_time_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [95:0] exp_time;
  logic [39:0] exp_inc;
  logic [95:0] exp_rb;
  logic [31:0] m_sh_lo, m_sh_hi, m_adj_lo, m_adj_hi;

  always #4 clk = ~clk;

  phc_shadow_timer i_phc_shadow_timer (
    .clk, .rst_n, .tick, .bus_wr, .bus_addr, .bus_wdata,
    .bus_rdata, .time_o, .port_time_o
  );

  task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_time(string tag);
    chk(tag, time_o, exp_time);
    chk({tag, " R10 mirror"}, {32'h0, port_time_o}, {32'h0, exp_time[63:0]});
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic set_reg(logic [3:0] a, logic [31:0] d);
    bus_write(a, d);
    case (a)
      4'h0: m_sh_lo = d;
      4'h1: m_sh_hi = d;
      4'h2: m_adj_lo = d;
      4'h3: m_adj_hi = d;
      default: ;
    endcase
  endtask

  task automatic read_reg(logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic run_cmd(logic [2:0] code);
    bus_write(4'h4, {29'h0, code});
    bus_write(4'h5, 32'h1);
    @(negedge clk);
    case (code)
      3'd1: exp_time = {m_sh_hi, m_sh_lo, 32'h0};
      3'd2: exp_inc = {m_adj_hi[7:0], m_adj_lo};
      3'd3, 3'd5: exp_time = exp_time + {{32{m_adj_hi[31]}}, m_adj_hi, 32'h0};
      3'd4: exp_rb = exp_time;
      default: ;
    endcase
  endtask

  task automatic run_ticks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    exp_time = exp_time + 96'(exp_inc) * 96'(n);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [95:0] held;
    exp_time = '0; exp_inc = 40'h01_0000_0000; exp_rb = '0;
    m_sh_lo = 0; m_sh_hi = 0; m_adj_lo = 0; m_adj_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_time("R1 reset time");
    read_reg(4'h4, v); chk("R1 cmd reset", {64'h0, v}, 96'h0);
    read_reg(4'h7, v); chk("R1 readback reset", {64'h0, v}, 96'h0);
    run_ticks(1);
    chk_time("R1 reset increment 1ns");

    // R3 staging without a valid trigger
    set_reg(4'h1, 32'h0000_0012);
    set_reg(4'h0, 32'hFFFF_FFFE);
    bus_write(4'h4, 32'h1);
    repeat (3) @(negedge clk);
    chk_time("R3 no trigger no change");
    bus_write(4'h5, 32'h2);
    @(negedge clk);
    chk_time("R3 wrong trigger value ignored");
    read_reg(4'h4, v); chk("R3 cmd kept", {64'h0, v}, 96'h1);

    // R4 timing: trigger, then applied one edge later
    bus_write(4'h5, 32'h1);
    chk_time("R4 not yet applied at trigger edge");
    @(negedge clk);
    exp_time = {m_sh_hi, m_sh_lo, 32'h0};
    chk_time("R5 load time applied");
    read_reg(4'h4, v); chk("R9 cmd cleared", {64'h0, v}, 96'h0);

    // R2 carry low into high
    run_ticks(3);
    chk_time("R2 carry into high word");

    // R6 load increment, upper bits ignored
    set_reg(4'h3, 32'hABCD_EF01);
    set_reg(4'h2, 32'h8000_0000);
    run_cmd(3'd2);
    run_ticks(5);
    chk_time("R6 fractional increment with masked high bits");

    // R2/R6 sweep of increments and tick counts
    for (int k = 0; k < 8; k++) begin
      set_reg(4'h3, 32'(k * 37));
      set_reg(4'h2, 32'(k * 32'h2468ACE1));
      run_cmd(3'd2);
      run_ticks(k + 1);
      chk_time($sformatf("R2 sweep step %0d", k));
    end

    // R7 shift sweep, both codes, signed
    for (int k = 0; k < 6; k++) begin
      set_reg(4'h2, 32'hDEAD_BEEF);
      set_reg(4'h3, (k % 2 == 1) ? 32'(-(k * 1000 + 7)) : 32'(k * 123457));
      run_cmd((k % 3 == 0) ? 3'd5 : 3'd3);
      chk_time($sformatf("R7 shift step %0d", k));
    end

    // R7 borrow across words
    set_reg(4'h1, 32'h1);
    set_reg(4'h0, 32'h2);
    run_cmd(3'd1);
    set_reg(4'h3, 32'hFFFF_FFFB);
    run_cmd(3'd3);
    chk_time("R7 negative shift with borrow");

    // R8 snapshot coherence
    run_ticks(4);
    run_cmd(3'd4);
    held = exp_rb;
    run_ticks(9);
    read_reg(4'h6, v); chk("R8 readback fraction", {64'h0, v}, {64'h0, held[31:0]});
    read_reg(4'h7, v); chk("R8 readback low", {64'h0, v}, {64'h0, held[63:32]});
    read_reg(4'h8, v); chk("R8 readback high", {64'h0, v}, {64'h0, held[95:64]});
    chk_time("R8 time moved on");

    // R9 undefined codes and empty trigger
    run_cmd(3'd7);
    read_reg(4'h4, v); chk("R9 cmd cleared after code 7", {64'h0, v}, 96'h0);
    run_cmd(3'd0);
    run_cmd(3'd6);
    run_ticks(2);
    chk_time("R9 undefined codes no effect");

    // R2 full wrap of 96 bits
    set_reg(4'h3, 32'h1); set_reg(4'h2, 32'h0);
    run_cmd(3'd2);
    set_reg(4'h1, 32'hFFFF_FFFF);
    set_reg(4'h0, 32'hFFFF_FFFF);
    run_cmd(3'd1);
    run_ticks(1);
    chk_time("R2 wrap to zero");

    finish_run();
  end
endmodule